// File: doc/BRIEF.md
# SPI Slave-Enable Handshake Timeout Monitor

This block sits beside the shift engine of an SPI master and supervises the optional ready line that some slaves drive back to the master. When the master raises chip-select, the slave has a programmable number of SPI bit periods to assert its enable line. When chip-select is released, the slave has a second programmable number of bit periods to drop it again. A slave that misses the first window sets a sticky TIMEOUT flag. A slave that misses the second window sets a sticky DESYNC flag, and DESYNC is also raised when enable drops while a character is still being shifted. Either flag can raise an interrupt through its own enable bit.

The shift engine supplies a one-cycle bit-rate strobe, the chip-select level and a pulse when the final bit of a character has gone out. Software loads both limits through one 16-bit write and clears flags by writing ones. The enable line from the slave is asynchronous and passes through a synchronizer inside the block. A limit of N bit periods gives a window of N divided by the bit rate. For example, 16 periods at 8 Mbit/s is 2 µs.

Top module: `spi_hs_monitor`

## Requirements
- R1: Both checks and the early-release check are bypassed unless `master_mode` and `hs_enable` are both 1. While bypassed, neither flag is set.
- R2: A `reg_wr` pulse loads `reg_wdata`. Bits 7:0 hold the chip-select-to-enable limit and bits 15:8 hold the release limit. The reset value of both limits is 0.
- R3: After `cs_active` rises, the bit strobes are numbered 0, 1, 2 and so on. If synchronized enable is still low on strobe number `limit`, `flag_timeout` becomes 1 at that clock edge.
- R4: Once synchronized enable is seen high during the chip-select window, the setup check ends, and later strobes set no TIMEOUT.
- R5: After `cs_active` falls, the bit strobes are numbered 0, 1, 2 and so on. If synchronized enable is still high on strobe number `limit`, `flag_desync` becomes 1 at that edge. Seeing enable low ends the check.
- R6: If synchronized enable falls while `cs_active` is 1 and no `xfer_done` pulse has occurred since chip-select rose, `flag_desync` is set.
- R7: A limit of 0 fails on strobe 0 unless the awaited enable level is already present.
- R8: Flags are sticky. A `flag_clr_wr` pulse clears each flag whose bit in `flag_clr` is 1: bit 0 is TIMEOUT and bit 1 is DESYNC. A set in the same cycle wins over a clear.
- R9: `irq` is 1 exactly when a set flag has its enable bit set in `irq_en`: bit 0 is TIMEOUT and bit 1 is DESYNC.
- R10: `ena_in` passes through two flops. A change on `ena_in` is seen by the checks two clock edges later, and a resulting flag appears on the third edge.
- R11: After reset, both flags and `irq` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Synchronous active-low reset |
| master_mode | input | 1 | 1 when the SPI runs as master |
| hs_enable | input | 1 | 1 when the addressed slave uses the enable handshake |
| cs_active | input | 1 | Chip-select asserted (active high) |
| xfer_done | input | 1 | Pulse: final bit of the character transmitted |
| bit_tick | input | 1 | One-cycle strobe per SPI bit period |
| ena_in | input | 1 | Asynchronous slave enable, active high |
| reg_wr | input | 1 | Load strobe for the limit register |
| reg_wdata | input | 16 | Limit register value (15:8 release, 7:0 setup) |
| flag_clr_wr | input | 1 | Write-one-to-clear strobe for the flags |
| flag_clr | input | 2 | Flags to clear (bit 0 TIMEOUT, bit 1 DESYNC) |
| irq_en | input | 2 | Interrupt enables (bit 0 TIMEOUT, bit 1 DESYNC) |
| flag_timeout | output | 1 | Sticky setup-timeout flag |
| flag_desync | output | 1 | Sticky desynchronization flag |
| irq | output | 1 | Interrupt request |

## Verification
A flag from a window check is registered on the edge that samples the failing bit strobe. The bench therefore reads flags at the falling edge that follows that strobe. A change on `ena_in` needs two edges to reach the checks, so the bench moves enable just after strobe d-1, which lets it count by strobe d. A flag from an early release lands on the third edge after the input change, and a directed test reads it on both sides of that edge. `irq` is combinational from the flags and enables, so it is read half a cycle after a change to either.

// File: rtl/spi_hs_pkg.sv
// Package: shared widths, flag indices and the limit register layout for
// the SPI handshake monitor. Assumes 8-bit limits packed into one word.
package spi_hs_pkg;
    localparam int DLY_W     = 8;
    localparam int REG_W     = 2 * DLY_W;
    localparam int NUM_FLAGS = 2;
    localparam int FLAG_TO   = 0;   // setup (chip-select to enable) timeout
    localparam int FLAG_DS   = 1;   // desynchronization

    // Limit register: release limit in the upper byte, setup limit in the lower.
    typedef struct packed {
        logic [DLY_W-1:0] rel_lim;
        logic [DLY_W-1:0] setup_lim;
    } hs_limits_t;
endpackage

// File: rtl/hs_ena_sync.sv
// Synchronizer and edge detector for the slave enable line.
// Assumes ena_async is asynchronous to clk; STAGES >= 2.
module hs_ena_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ena_async,
    output logic ena_lvl,
    output logic ena_rise,
    output logic ena_fall
);
    logic [STAGES-1:0] sync_q;
    logic              lvl_d;

    // Shift the asynchronous level through the synchronizer chain.
    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[STAGES-2:0], ena_async};
    end

    // Remember the previous synchronized level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) lvl_d <= 1'b0;
        else        lvl_d <= sync_q[STAGES-1];
    end

    assign ena_lvl  = sync_q[STAGES-1];
    assign ena_rise = ena_lvl & ~lvl_d;
    assign ena_fall = ~ena_lvl & lvl_d;
endmodule

// File: rtl/hs_window.sv
// One handshake window: counts bit strobes after a start event and fires
// when the awaited enable level has not appeared by strobe number `limit`.
// WAIT_HIGH selects whether enable high (setup) or low (release) ends it.
// Assumes start and abort are never both asserted meaningfully together;
// start takes priority.
module hs_window #(
    parameter int CNT_W     = 8,
    parameter bit WAIT_HIGH = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             abort,
    input  logic             tick,
    input  logic             ena_lvl,
    input  logic [CNT_W-1:0] limit,
    output logic             busy,
    output logic [CNT_W-1:0] cnt,
    output logic             fire
);
    logic level_ok;

    // Pick the enable level that satisfies this window.
    generate
        if (WAIT_HIGH) begin : g_wait_high
            assign level_ok = ena_lvl;
        end else begin : g_wait_low
            assign level_ok = ~ena_lvl;
        end
    endgenerate

    // Failure: still waiting when the strobe at the limit arrives.
    assign fire = busy & ~start & ~abort & ~level_ok & tick & (cnt >= limit);

    // Arm, count strobes and disarm on success, abort or failure.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy <= 1'b0;
            cnt  <= '0;
        end else if (start) begin
            busy <= 1'b1;
            cnt  <= '0;
        end else if (busy) begin
            if (abort || level_ok || fire) begin
                busy <= 1'b0;
            end else if (tick) begin
                cnt <= cnt + 1'b1;
            end
        end
    end
endmodule

// File: rtl/hs_flags.sv
// Sticky status flags with write-one-to-clear and a masked interrupt.
// Assumes set requests are single-cycle pulses; set wins over clear.
module hs_flags #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_req,
    input  logic         clr_wr,
    input  logic [N-1:0] clr_mask,
    input  logic [N-1:0] irq_en,
    output logic [N-1:0] flags,
    output logic         irq
);
    genvar i;
    generate
        for (i = 0; i < N; i++) begin : g_flag
            // Hold one flag: set on request, clear on write of one.
            always_ff @(posedge clk) begin
                if (!rst_n)                      flags[i] <= 1'b0;
                else if (set_req[i])             flags[i] <= 1'b1;
                else if (clr_wr && clr_mask[i])  flags[i] <= 1'b0;
            end
        end
    endgenerate

    assign irq = |(flags & irq_en);
endmodule

// File: rtl/spi_hs_monitor.sv
// Top: supervises the slave enable handshake of an SPI master. Runs a setup
// window from chip-select assertion and a release window from chip-select
// deassertion, plus an early-release check during the character.
// Assumes bit_tick is a single-cycle strobe at the SPI bit rate and that
// cs_active and xfer_done are synchronous to clk.
module spi_hs_monitor
    import spi_hs_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             master_mode,
    input  logic             hs_enable,
    input  logic             cs_active,
    input  logic             xfer_done,
    input  logic             bit_tick,
    input  logic             ena_in,
    input  logic             reg_wr,
    input  logic [REG_W-1:0] reg_wdata,
    input  logic             flag_clr_wr,
    input  logic [1:0]       flag_clr,
    input  logic [1:0]       irq_en,
    output logic             flag_timeout,
    output logic             flag_desync,
    output logic             irq
);
    hs_limits_t           limits_q;
    logic                 cs_q;
    logic                 done_seen;
    logic                 mon_on;
    logic                 cs_rise, cs_fall;
    logic                 ena_lvl, ena_rise, ena_fall;
    logic                 setup_busy, rel_busy;
    logic [DLY_W-1:0]     setup_cnt, rel_cnt;
    logic                 setup_fire, rel_fire;
    logic                 early_rel;
    logic [NUM_FLAGS-1:0] set_req;
    logic [NUM_FLAGS-1:0] flags;

    assign mon_on  = master_mode & hs_enable;
    assign cs_rise = cs_active & ~cs_q;
    assign cs_fall = ~cs_active & cs_q;

    // Load both limits from the register write port.
    always_ff @(posedge clk) begin
        if (!rst_n)      limits_q <= '0;
        else if (reg_wr) limits_q <= hs_limits_t'(reg_wdata);
    end

    // Track chip-select for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) cs_q <= 1'b0;
        else        cs_q <= cs_active;
    end

    // Remember whether the final bit went out since chip-select rose.
    always_ff @(posedge clk) begin
        if (!rst_n)         done_seen <= 1'b0;
        else if (cs_rise)   done_seen <= 1'b0;
        else if (xfer_done) done_seen <= 1'b1;
    end

    hs_ena_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .ena_async (ena_in),
        .ena_lvl   (ena_lvl),
        .ena_rise  (ena_rise),
        .ena_fall  (ena_fall)
    );

    hs_window #(.CNT_W(DLY_W), .WAIT_HIGH(1'b1)) u_setup_win (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (mon_on & cs_rise),
        .abort   (~mon_on | ~cs_active),
        .tick    (bit_tick),
        .ena_lvl (ena_lvl),
        .limit   (limits_q.setup_lim),
        .busy    (setup_busy),
        .cnt     (setup_cnt),
        .fire    (setup_fire)
    );

    hs_window #(.CNT_W(DLY_W), .WAIT_HIGH(1'b0)) u_rel_win (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (mon_on & cs_fall),
        .abort   (~mon_on | cs_active),
        .tick    (bit_tick),
        .ena_lvl (ena_lvl),
        .limit   (limits_q.rel_lim),
        .busy    (rel_busy),
        .cnt     (rel_cnt),
        .fire    (rel_fire)
    );

    // Enable dropping while the character is still in flight.
    assign early_rel = mon_on & cs_active & ~done_seen & ~xfer_done & ena_fall;

    assign set_req[FLAG_TO] = setup_fire;
    assign set_req[FLAG_DS] = rel_fire | early_rel;

    hs_flags #(.N(NUM_FLAGS)) u_flags (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_req  (set_req),
        .clr_wr   (flag_clr_wr),
        .clr_mask (flag_clr),
        .irq_en   (irq_en),
        .flags    (flags),
        .irq      (irq)
    );

    assign flag_timeout = flags[FLAG_TO];
    assign flag_desync  = flags[FLAG_DS];
endmodule

// File: rtl/spi_hs_monitor_chk.sv
// Checker for spi_hs_monitor, attached by bind. Relates ports and the
// internal window state over time.
module spi_hs_monitor_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       master_mode,
    input logic       hs_enable,
    input logic       cs_active,
    input logic       bit_tick,
    input logic       flag_clr_wr,
    input logic [1:0] flag_clr,
    input logic [1:0] irq_en,
    input logic       flag_timeout,
    input logic       flag_desync,
    input logic       irq,
    input logic       setup_busy,
    input logic       ena_lvl
);
    // R1: no flag may appear while the monitor is bypassed.
    assert_bypass_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (!(master_mode && hs_enable) && !flag_clr_wr) |=> $stable({flag_timeout, flag_desync}));

    // R3: TIMEOUT only rises on a bit strobe.
    assert_timeout_on_tick_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_timeout) |-> $past(bit_tick));

    // R4: seeing enable high ends the setup window.
    assert_setup_ends_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (setup_busy && ena_lvl) |=> !setup_busy);

    // R5 and R6: DESYNC rises on a strobe or during chip-select.
    assert_desync_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_desync) |-> $past(bit_tick || cs_active));

    // R8: a set flag stays set unless cleared.
    assert_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_timeout && !(flag_clr_wr && flag_clr[0])) |=> flag_timeout);

    assert_clear_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(flag_desync) |-> $past(flag_clr_wr && flag_clr[1]));

    // R9: interrupt needs a flag and an enable.
    assert_irq_needs_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> ((flag_timeout && irq_en[0]) || (flag_desync && irq_en[1])));
endmodule

bind spi_hs_monitor spi_hs_monitor_chk chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .master_mode  (master_mode),
    .hs_enable    (hs_enable),
    .cs_active    (cs_active),
    .bit_tick     (bit_tick),
    .flag_clr_wr  (flag_clr_wr),
    .flag_clr     (flag_clr),
    .irq_en       (irq_en),
    .flag_timeout (flag_timeout),
    .flag_desync  (flag_desync),
    .irq          (irq),
    .setup_busy   (setup_busy),
    .ena_lvl      (ena_lvl)
);

// File: tb/spi_hs_monitor_tb_top.sv
`timescale 1ns/1ps
module spi_hs_monitor_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        master_mode = 1'b1;
    logic        hs_enable = 1'b1;
    logic        cs_active = 1'b0;
    logic        xfer_done = 1'b0;
    logic        bit_tick = 1'b0;
    logic        ena_in = 1'b0;
    logic        reg_wr = 1'b0;
    logic [15:0] reg_wdata = '0;
    logic        flag_clr_wr = 1'b0;
    logic [1:0]  flag_clr = '0;
    logic [1:0]  irq_en = 2'b11;
    logic        flag_timeout, flag_desync, irq;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    spi_hs_monitor dut_i (
        .clk(clk), .rst_n(rst_n), .master_mode(master_mode), .hs_enable(hs_enable),
        .cs_active(cs_active), .xfer_done(xfer_done), .bit_tick(bit_tick),
        .ena_in(ena_in), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
        .flag_clr_wr(flag_clr_wr), .flag_clr(flag_clr), .irq_en(irq_en),
        .flag_timeout(flag_timeout), .flag_desync(flag_desync), .irq(irq)
    );

    // Vector: [15:12] kind (0 setup, 1 release), [11:8] limit, [7:4] strobe
    // by which enable reaches its awaited level, [3:0] expected flag.
    localparam int NV = 10;
    localparam logic [15:0] VEC [NV] = '{
        16'h0_3_2_0, 16'h0_3_3_0, 16'h0_3_4_1, 16'h0_0_0_0, 16'h0_0_1_1,
        16'h1_2_2_0, 16'h1_2_3_1, 16'h1_0_0_0, 16'h1_0_1_1, 16'h0_6_7_1
    };

    task automatic check(input string req, input string what, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s: actual=%0b expected=%0b", req, what, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; cs_active = 1'b0; ena_in = 1'b0; bit_tick = 1'b0;
        xfer_done = 1'b0; reg_wr = 1'b0; flag_clr_wr = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic write_limits(input logic [7:0] rel, input logic [7:0] setup);
        @(negedge clk); reg_wr = 1'b1; reg_wdata = {rel, setup};
        @(negedge clk); reg_wr = 1'b0;
    endtask

    task automatic do_tick();
        repeat (3) @(negedge clk);
        bit_tick = 1'b1;
        @(negedge clk);
        bit_tick = 1'b0;
    endtask

    // Setup window: enable rises after strobe d-1 (or before cs when d=0).
    task automatic run_setup(input int lim, input int d);
        write_limits(8'd40, 8'(lim));
        if (d == 0) begin ena_in = 1'b1; repeat (3) @(negedge clk); end
        cs_active = 1'b1;
        for (int k = 0; k <= ((lim > d) ? lim : d) + 1; k++) begin
            do_tick();
            if (k + 1 == d) ena_in = 1'b1;
        end
    endtask

    // Release window: enable falls after strobe d-1 (or before cs drop when d=0).
    task automatic run_release(input int lim, input int d);
        write_limits(8'(lim), 8'd40);
        ena_in = 1'b1; repeat (3) @(negedge clk);
        cs_active = 1'b1; repeat (4) @(negedge clk);
        xfer_done = 1'b1; @(negedge clk); xfer_done = 1'b0;
        if (d == 0) begin ena_in = 1'b0; repeat (3) @(negedge clk); end
        cs_active = 1'b0;
        for (int k = 0; k <= ((lim > d) ? lim : d) + 1; k++) begin
            do_tick();
            if (k + 1 == d) ena_in = 1'b0;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        // R11: reset state.
        do_reset();
        @(negedge clk);
        check("R11", "timeout after reset", flag_timeout, 1'b0);
        check("R11", "desync after reset", flag_desync, 1'b0);
        check("R11", "irq after reset", irq, 1'b0);

        // Table walk: R3, R4, R5, R7 and field placement R2, irq R9.
        for (int v = 0; v < NV; v++) begin
            logic [3:0] kind, lim, d, ex;
            {kind, lim, d, ex} = VEC[v];
            do_reset();
            if (kind == 4'd0) begin
                run_setup(int'(lim), int'(d));
                check((lim == 0) ? "R7" : ((d <= lim) ? "R4" : "R3"), "setup timeout (R2 field)", flag_timeout, ex[0]);
                check("R3", "no desync in setup test", flag_desync, 1'b0);
            end else begin
                run_release(int'(lim), int'(d));
                check((lim == 0) ? "R7" : "R5", "release desync (R2 field)", flag_desync, ex[0]);
                check("R5", "no timeout in release test", flag_timeout, 1'b0);
            end
            check("R9", "irq follows flag", irq, ex[0]);
        end

        // R1: bypass when not master, and when handshake unused.
        do_reset(); master_mode = 1'b0;
        run_setup(0, 5);
        check("R1", "timeout bypassed not master", flag_timeout, 1'b0);
        do_reset(); master_mode = 1'b1; hs_enable = 1'b0;
        run_setup(0, 5);
        check("R1", "timeout bypassed no handshake", flag_timeout, 1'b0);
        hs_enable = 1'b1;

        // R6 and R10: early release, with the synchronizer latency.
        do_reset();
        write_limits(8'd40, 8'd40);
        ena_in = 1'b1; repeat (3) @(negedge clk);
        cs_active = 1'b1; repeat (5) @(negedge clk);
        ena_in = 1'b0;
        repeat (2) @(negedge clk);
        check("R10", "desync not yet after two edges", flag_desync, 1'b0);
        @(negedge clk);
        check("R6", "early release desync on third edge", flag_desync, 1'b1);

        // R6: release after xfer_done inside cs is not early.
        do_reset();
        write_limits(8'd40, 8'd40);
        ena_in = 1'b1; repeat (3) @(negedge clk);
        cs_active = 1'b1; repeat (3) @(negedge clk);
        xfer_done = 1'b1; @(negedge clk); xfer_done = 1'b0;
        ena_in = 1'b0; repeat (4) @(negedge clk);
        check("R6", "release after done not flagged", flag_desync, 1'b0);

        // R8 and R9: sticky flag, selective clear, irq gating.
        do_reset();
        run_setup(1, 4);
        check("R8", "timeout set", flag_timeout, 1'b1);
        irq_en = 2'b10; @(negedge clk);
        check("R9", "irq masked", irq, 1'b0);
        irq_en = 2'b01; @(negedge clk);
        check("R9", "irq unmasked", irq, 1'b1);
        flag_clr_wr = 1'b1; flag_clr = 2'b10; @(negedge clk); flag_clr_wr = 1'b0;
        check("R8", "timeout kept on other-bit clear", flag_timeout, 1'b1);
        repeat (3) @(negedge clk);
        check("R8", "timeout still sticky", flag_timeout, 1'b1);
        flag_clr_wr = 1'b1; flag_clr = 2'b01; @(negedge clk); flag_clr_wr = 1'b0;
        check("R8", "timeout cleared by bit 0", flag_timeout, 1'b0);
        check("R9", "irq drops with flag", irq, 1'b0);
        irq_en = 2'b11;

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule